// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the entry half of processor exception handling. A requester hands it an exception through a valid/ready channel. The vector number comes from one of two sources: a device acknowledge path (`dev_vec`) or an internally generated code (`int_vec`), and `req_from_dev` picks between them. With the same handshake the requester supplies the current program counter, status word and supervisor stack pointer. The block then works through four phases in a fixed order:

1. It keeps a private copy of the status word and emits an updated status word that selects supervisor mode with tracing off.
2. It forms the handler-table address from a relocatable base register.
3. It pushes a four-word frame onto the supervisor stack.
4. It reads the 32-bit handler address as two 16-bit words and hands back the new program counter and the new stack pointer.

The channel follows the usual back-pressure rule. The request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the block is idle. A requester may hold `req_valid` high for as long as it likes without effect until `req_ready` returns. Memory traffic uses a plain request/acknowledge pair, and the block holds every field of a request steady until the acknowledge arrives. The table base register is written through a plain control port, and its value can be read back.

Top module: `exc_entry_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. When `req_valid` and `req_ready` are both high at a clock edge, the request is accepted. From the next cycle `busy` is high and `req_ready` is low, and this lasts up to and including the cycle in which `pc_load` pulses. `busy` is low in the cycle after that.
- R2: When `req_from_dev`=1 at acceptance, the vector number is `dev_vec`. When `req_from_dev`=0, it is `int_vec`.
- R3: In the first cycle after acceptance, `sr_load` pulses for one cycle. `sr_new` equals the captured status word with bit 13 (supervisor) set to 1, bits 15:14 (trace) cleared to 0, and all other bits unchanged.
- R4: The table address is `vbr_q + vector*4`, taken modulo 2^32. The handler high word is read at that address and the low word at that address + 2, in that order.
- R5: While `vbr_we`=1, `vbr_wdata` loads into the base register, and `vbr_q` shows the new value from the next cycle. Later exceptions use the new value. At reset the base register is zero.
- R6: The frame is written with exactly four word writes, at addresses `ssp-2`, `ssp-4`, `ssp-6` and `ssp-8`. The data in that order is PC[15:0], PC[31:16], the captured status word, and the format word.
- R7: The format word carries the format code (parameter `FMT_CODE`, default 0) in bits 15:12 and the vector offset (vector*4) in bits 11:0.
- R8: While `mem_req`=1 and `mem_ack`=0, the next cycle keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged. Each access completes only in a cycle with `mem_ack`=1, whatever the number of wait cycles.
- R9: `pc_load` pulses for one cycle only after both handler reads have completed. In that cycle `pc_new` = {high word, low word}, `ssp_load`=1 and `ssp_new` = `ssp - 8`.
- R10: `sr_load`, `pc_load` and `mem_req` are never high in the same cycle. All frame writes finish before the first handler read, and the status update comes before any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request valid |
| req_ready | output | 1 | Block can accept a request |
| req_from_dev | input | 1 | 1 selects the device vector, 0 the internal vector |
| dev_vec | input | 8 | Vector number from device acknowledge |
| int_vec | input | 8 | Internally generated vector number |
| pc_in | input | 32 | Program counter at exception time |
| sr_in | input | 16 | Status word at exception time |
| ssp_in | input | 32 | Supervisor stack pointer at exception time |
| busy | output | 1 | Exception entry in progress |
| sr_load | output | 1 | Pulse: load `sr_new` into the status register |
| sr_new | output | 16 | Status word for exception mode |
| pc_load | output | 1 | Pulse: load `pc_new` and resume |
| pc_new | output | 32 | Handler address |
| ssp_load | output | 1 | Pulse: load `ssp_new` |
| ssp_new | output | 32 | Stack pointer after the frame |
| vbr_we | input | 1 | Base register write enable |
| vbr_wdata | input | 32 | Base register write data |
| vbr_q | output | 32 | Base register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
The assertions check four things on every cycle:
- a pending memory request stays frozen until it is acknowledged;
- the status update, the program-counter load and memory requests never overlap;
- each status update selects supervisor mode with tracing off;
- an accepted request is followed by `busy`, and a program-counter load is followed by idle.

Only the bench scenarios can show the values themselves:
- that the right vector source was used;
- the exact frame addresses, contents and order;
- the arithmetic of the table address, including wrap past the top of the address space;
- the effect of relocating the base register;
- the assembled handler address under different acknowledge latencies.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SR, ST_VEC, ST_PCL, ST_PCH, ST_SRW, ST_FMT, ST_RHI, ST_RLO, ST_LOAD
  } exc_state_t;

  localparam int SR_SUP_BIT  = 13;
  localparam int SR_TRACE_LO = 14;
  localparam int SR_TRACE_HI = 15;
endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [VW-1:0] vec,
  output logic [AW-1:0] addr
);
  localparam int PADW = AW - VW - 2;
  logic [AW-1:0] offset;
  assign offset = {{PADW{1'b0}}, vec, 2'b00};
  assign addr   = base + offset;
endmodule

// File: rtl/exc_sr_mode.sv
module exc_sr_mode #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] sr_in,
  output logic [SW-1:0] sr_out
);
  import exc_pkg::*;
  always_comb begin
    sr_out = sr_in;
    sr_out[SR_SUP_BIT] = 1'b1;
    for (int i = SR_TRACE_LO; i <= SR_TRACE_HI; i++) sr_out[i] = 1'b0;
  end
endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word #(
  parameter int DW = 16,
  parameter int VW = 8,
  parameter int FMTW = 4,
  parameter logic [FMTW-1:0] FMT_CODE = '0
) (
  input  exc_pkg::exc_state_t st,
  input  logic [2*DW-1:0]     pc,
  input  logic [DW-1:0]       sr,
  input  logic [VW-1:0]       vec,
  output logic [DW-1:0]       wdata
);
  import exc_pkg::*;
  localparam int OFFW = DW - FMTW;
  localparam int PADW = OFFW - VW - 2;
  logic [DW-1:0] fmt_word;
  assign fmt_word = {FMT_CODE, {PADW{1'b0}}, vec, 2'b00};
  always_comb begin
    unique case (st)
      ST_PCL:  wdata = pc[DW-1:0];
      ST_PCH:  wdata = pc[2*DW-1:DW];
      ST_SRW:  wdata = sr;
      ST_FMT:  wdata = fmt_word;
      default: wdata = '0;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int VW = 8,
  parameter int FMTW = 4,
  parameter logic [FMTW-1:0] FMT_CODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_from_dev,
  input  logic [VW-1:0] dev_vec,
  input  logic [VW-1:0] int_vec,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0] sr_in,
  input  logic [AW-1:0] ssp_in,
  output logic          busy,
  output logic          sr_load,
  output logic [DW-1:0] sr_new,
  output logic          pc_load,
  output logic [2*DW-1:0] pc_new,
  output logic          ssp_load,
  output logic [AW-1:0] ssp_new,
  input  logic          vbr_we,
  input  logic [AW-1:0] vbr_wdata,
  output logic [AW-1:0] vbr_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import exc_pkg::*;
  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);

  exc_state_t     st;
  logic [VW-1:0]  vec_q;
  logic [2*DW-1:0] pc_q;
  logic [DW-1:0]  sr_q;
  logic [AW-1:0]  sp_q;
  logic [AW-1:0]  va_q;
  logic [AW-1:0]  va_calc;
  logic [DW-1:0]  hi_q;
  logic [DW-1:0]  lo_q;
  logic [DW-1:0]  fw_data;
  logic           pushing;
  logic           reading;
  logic           accept;

  exc_vec_addr #(.AW(AW), .VW(VW)) u_va (.base(vbr_q), .vec(vec_q), .addr(va_calc));
  exc_sr_mode  #(.SW(DW)) u_sr (.sr_in(sr_q), .sr_out(sr_new));
  exc_frame_word #(.DW(DW), .VW(VW), .FMTW(FMTW), .FMT_CODE(FMT_CODE)) u_fw (
    .st(st), .pc(pc_q), .sr(sr_q), .vec(vec_q), .wdata(fw_data));

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign pushing   = (st == ST_PCL) || (st == ST_PCH) || (st == ST_SRW) || (st == ST_FMT);
  assign reading   = (st == ST_RHI) || (st == ST_RLO);
  assign mem_req   = pushing || reading;
  assign mem_we    = pushing;
  assign mem_addr  = pushing ? (sp_q - WSTEP) : ((st == ST_RLO) ? (va_q + WSTEP) : va_q);
  assign mem_wdata = fw_data;
  assign sr_load   = (st == ST_SR);
  assign pc_load   = (st == ST_LOAD);
  assign ssp_load  = (st == ST_LOAD);
  assign pc_new    = {hi_q, lo_q};
  assign ssp_new   = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vbr_q <= '0;
    else if (vbr_we) vbr_q <= vbr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      vec_q <= '0; pc_q <= '0; sr_q <= '0; sp_q <= '0;
      va_q <= '0; hi_q <= '0; lo_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          vec_q <= req_from_dev ? dev_vec : int_vec;
          pc_q  <= pc_in;
          sr_q  <= sr_in;
          sp_q  <= ssp_in;
          st    <= ST_SR;
        end
        ST_SR:  st <= ST_VEC;
        ST_VEC: begin va_q <= va_calc; st <= ST_PCL; end
        ST_PCL: if (mem_ack) begin sp_q <= sp_q - WSTEP; st <= ST_PCH; end
        ST_PCH: if (mem_ack) begin sp_q <= sp_q - WSTEP; st <= ST_SRW; end
        ST_SRW: if (mem_ack) begin sp_q <= sp_q - WSTEP; st <= ST_FMT; end
        ST_FMT: if (mem_ack) begin sp_q <= sp_q - WSTEP; st <= ST_RHI; end
        ST_RHI: if (mem_ack) begin hi_q <= mem_rdata; st <= ST_RLO; end
        ST_RLO: if (mem_ack) begin lo_q <= mem_rdata; st <= ST_LOAD; end
        ST_LOAD: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
  assert_sr_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> (sr_new[SR_SUP_BIT] && !sr_new[SR_TRACE_HI] && !sr_new[SR_TRACE_LO]));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  assert_pc_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (!busy && req_ready));
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_load, pc_load, mem_req}));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_from_dev = 1'b0;
  logic [7:0]  dev_vec = '0, int_vec = '0;
  logic [31:0] pc_in = '0, ssp_in = '0, vbr_wdata = '0;
  logic [15:0] sr_in = '0;
  logic        vbr_we = 1'b0;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        req_ready, busy, sr_load, pc_load, ssp_load, mem_req, mem_we;
  logic [15:0] sr_new, mem_wdata;
  logic [31:0] pc_new, ssp_new, vbr_q, mem_addr;

  exc_entry_seq dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int delay = 0, wcnt = 0;
  logic [31:0] wr_addr [8];
  logic [15:0] wr_data [8];
  logic [31:0] rd_addr [4];
  int wr_n = 0, rd_n = 0;
  bit order_bad = 0, sr_seen = 0, pc_seen = 0, mem_before_sr = 0;
  int sr_cnt = 0;
  logic [15:0] sr_got;
  logic [31:0] pc_got, ssp_got;

  function automatic logic [15:0] memf(logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sr_load) begin sr_seen = 1; sr_cnt++; sr_got = sr_new; end
    if (pc_load && ssp_load) begin pc_seen = 1; pc_got = pc_new; ssp_got = ssp_new; end
    if (mem_ack) begin
      mem_ack = 0; wcnt = 0;
    end else if (mem_req) begin
      if (!sr_seen) mem_before_sr = 1;
      if (wcnt >= delay) begin
        mem_ack = 1;
        mem_rdata = memf(mem_addr);
        if (mem_we) begin
          if (rd_n > 0) order_bad = 1;
          if (wr_n < 8) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
          wr_n++;
        end else begin
          if (rd_n < 4) rd_addr[rd_n] = mem_addr;
          rd_n++;
        end
      end else wcnt++;
    end
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic write_vbr(logic [31:0] v);
    @(negedge clk); vbr_we = 1; vbr_wdata = v;
    @(negedge clk); vbr_we = 0;
    chk(vbr_q == v, "R5 vbr readback", vbr_q, v);
  endtask

  task automatic run_exc(string name, bit from_dev, logic [7:0] dv, logic [7:0] iv,
                         logic [31:0] pc, logic [15:0] sr, logic [31:0] ssp, int dl);
    logic [7:0]  v;
    logic [31:0] va, ep;
    logic [15:0] es;
    int n;
    v  = from_dev ? dv : iv;
    va = vbr_q + {22'd0, v, 2'b00};
    es = sr; es[13] = 1; es[15:14] = 2'b00;
    ep = {memf(va), memf(va + 32'd2)};
    wr_n = 0; rd_n = 0; order_bad = 0; sr_seen = 0; pc_seen = 0; mem_before_sr = 0;
    sr_cnt = 0; delay = dl;
    @(negedge clk);
    req_valid = 1; req_from_dev = from_dev; dev_vec = dv; int_vec = iv;
    pc_in = pc; sr_in = sr; ssp_in = ssp;
    @(negedge clk);
    chk(busy && !req_ready, {name, " R1 busy after accept"}, {busy, req_ready}, 2'b10);
    pc_in = ~pc;  // held valid, must be ignored while busy
    @(negedge clk);
    chk(!req_ready, {name, " R1 ready low mid-entry"}, req_ready, 0);
    req_valid = 0;
    n = 0;
    while (!pc_seen && n < 500) begin @(posedge clk); n++; end
    @(negedge clk);
    chk(!busy && req_ready, {name, " R1 idle after load"}, {busy, req_ready}, 2'b01);
    chk(sr_seen && sr_got == es && sr_cnt == 1, {name, " R3 sr_new"}, sr_got, es);
    chk(wr_n == 4, {name, " R6 write count"}, wr_n, 4);
    chk(wr_addr[0] == ssp - 2 && wr_data[0] == pc[15:0], {name, " R6 push pc low"}, {wr_addr[0][15:0], wr_data[0]}, {16'(ssp - 2), pc[15:0]});
    chk(wr_addr[1] == ssp - 4 && wr_data[1] == pc[31:16], {name, " R6 push pc high"}, {wr_addr[1][15:0], wr_data[1]}, {16'(ssp - 4), pc[31:16]});
    chk(wr_addr[2] == ssp - 6 && wr_data[2] == sr, {name, " R6 push sr"}, {wr_addr[2][15:0], wr_data[2]}, {16'(ssp - 6), sr});
    chk(wr_addr[3] == ssp - 8 && wr_data[3] == {4'h0, 2'b00, v, 2'b00}, {name, " R7 format word"}, wr_data[3], {4'h0, 2'b00, v, 2'b00});
    chk(rd_n == 2 && rd_addr[0] == va && rd_addr[1] == va + 2, {name, " R4 R2 vector address"}, rd_addr[0], va);
    chk(pc_seen && pc_got == ep, {name, " R9 pc_new"}, pc_got, ep);
    chk(ssp_got == ssp - 8, {name, " R9 ssp_new"}, ssp_got, ssp - 8);
    chk(!order_bad && !mem_before_sr, {name, " R10 ordering"}, {order_bad, mem_before_sr}, 0);
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && !mem_req && !sr_load && !pc_load, "R1 reset idle", {req_ready, busy, mem_req}, 3'b100);
    chk(vbr_q == 0, "R5 reset base", vbr_q, 0);
  endtask

  initial begin
    test_reset();
    run_exc("internal", 0, 8'h11, 8'h05, 32'h1234_5678, 16'hC71F, 32'h0000_4000, 0);
    run_exc("device", 1, 8'h40, 8'h02, 32'hCAFE_0100, 16'h2704, 32'h0001_0010, 1);
    write_vbr(32'h0008_0000);
    run_exc("relocated R5", 0, 8'h00, 8'h1F, 32'h0000_0ABC, 16'h0000, 32'h0002_0000, 0);
    run_exc("waits R8", 1, 8'hFF, 8'h00, 32'h8000_0002, 16'hFFFF, 32'h0000_8000, 3);
    write_vbr(32'hFFFF_FF00);
    run_exc("wrap R4", 1, 8'h50, 8'h01, 32'h0102_0304, 16'h4000, 32'h0000_1000, 2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule